// File: doc/BRIEF.md
# Dynamic Bus Sizing Transfer Sequencer

This block is the bus-master side of a transfer engine for a bus whose slaves may be 8, 16 or 32 bits wide. It accepts one operand of 1 to 4 bytes at any byte address and cuts it into as many bus cycles as the slave needs. The slave's width is not known in advance. Each slave reports its width on a two-wire active-low acknowledge, and the sequencer works out from that width and the current address how many bytes the cycle moved.

Each bus cycle drives the full address, a 2-bit code for the bytes still to move, and, on writes, a data word with the remaining operand bytes placed so that a port of any width finds its bytes on the lanes it uses. On reads the sequencer picks the valid bytes out of the returned lanes and assembles them into a right-aligned result. After each acknowledge it advances the address, reduces the remaining count, and starts the next cycle until nothing remains. It then pulses `done`.

Top module: `dbs_sequencer`

## Requirements
- R1: After reset `busy`, `done` and `bus_cyc` are all low.
- R2: A request is taken only when `busy` is low. A `req_valid` raised while a transfer runs has no effect: the running transfer keeps its address and data, and `busy` is low in the cycle after its `done`.
- R3: `bus_siz` gives the bytes still to move in the current cycle, with 2'b00 = four, 2'b01 = one, 2'b10 = two and 2'b11 = three. The first cycle shows the full request size (`req_size` uses the same code).
- R4: `ack_n` is active low. 2'b00 reports a 32-bit port, 2'b01 (only bit 1 low) a 16-bit port, and 2'b10 (only bit 0 low) an 8-bit port. 2'b11 is no acknowledge, and the cycle waits.
- R5: The bytes a cycle moves equal the smaller of the bytes remaining and (port bytes minus address modulo port bytes). The next cycle's `bus_addr` is the old address plus that count.
- R6: While `bus_cyc` is high and no acknowledge has arrived, `bus_addr`, `bus_siz`, `bus_wdata` and `bus_cyc` hold their values.
- R7: Lane L of `bus_wdata` (lane 0 = bits 31:24, lane 3 = bits 7:0) carries remaining-operand byte k = L - (addr mod S). S is 1 for lane 0, 2 for lane 1 and 4 for lanes 2 and 3. Byte k = 0 is the next byte to send, and the operand is right-aligned in `req_wdata` with its most significant byte first in address order. Lanes with no such byte drive zero.
- R8: On reads, a port of width W returns its bytes on lanes (addr mod W) upward. The sequencer gathers them in address order into `rdata`, right-aligned, with the first byte most significant and unused upper bytes zero.
- R9: `done` is high for exactly one cycle, the cycle after the final acknowledge. In that cycle `busy` is low and `rdata` holds the full result.
- R10: Between two bus cycles of one transfer, `bus_cyc` is low for exactly one cycle.
- R11: A 4-byte write at an address with low bits 001 to a 16-bit port takes three cycles: size codes 00, 11, 01 at offsets 001, 010, 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address of the operand |
| req_size | input | 2 | Operand size code (as bus_siz) |
| req_wdata | input | 32 | Write operand, right-aligned |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Assembled read operand |
| bus_cyc | output | 1 | Bus cycle in progress |
| bus_write | output | 1 | Direction of the bus cycle |
| bus_addr | output | AW | Current byte address |
| bus_siz | output | 2 | Remaining-size code |
| bus_wdata | output | 32 | Steered write lanes |
| bus_rdata | input | 32 | Read lanes from the slave |
| ack_n | input | 2 | Active-low acknowledge with port width |

## Verification
The bound checker watches the properties that hold in every cycle. These are output stability while a cycle waits, an accepted byte count between one and the remaining size, the address and size step after each non-final acknowledge, the single idle cycle between bus cycles, and the one-cycle `done` that follows the final acknowledge. Which lanes carry which bytes, the assembled read value, and the cycle sequences for given addresses and widths can only be shown by the bench's scenarios. There a slave model of fixed or changing width stores or returns bytes on its own lanes and compares the outcome with a byte-addressed memory.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int DATA_W = LANES * BYTE_W;

  typedef enum logic [1:0] {PW_NONE = 2'd0, PW8 = 2'd1, PW16 = 2'd2, PW32 = 2'd3} port_w_e;
  typedef logic [2:0] cnt_t;  // byte count 0..4

  // active-low acknowledge pair to port width
  function automatic port_w_e ack_to_width(input logic [1:0] ack_n);
    case (ack_n)
      2'b00:   return PW32;
      2'b01:   return PW16;
      2'b10:   return PW8;
      default: return PW_NONE;
    endcase
  endfunction

  function automatic cnt_t width_bytes(input port_w_e w);
    case (w)
      PW8:     return 3'd1;
      PW16:    return 3'd2;
      PW32:    return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  // address modulo port width
  function automatic cnt_t port_offset(input logic [1:0] a, input port_w_e w);
    case (w)
      PW16:    return {2'b00, a[0]};
      PW32:    return {1'b0, a};
      default: return 3'd0;
    endcase
  endfunction

  function automatic cnt_t take_count(input cnt_t rem, input logic [1:0] a, input port_w_e w);
    cnt_t room;
    room = width_bytes(w) - port_offset(a, w);
    return (rem < room) ? rem : room;
  endfunction

  function automatic logic [1:0] size_code(input cnt_t rem);
    return rem[1:0];
  endfunction

  function automatic cnt_t size_decode(input logic [1:0] c);
    return (c == 2'b00) ? 3'd4 : {1'b0, c};
  endfunction

  // smallest port width that reaches lane l
  function automatic int lane_span(input int l);
    return (l == 0) ? 1 : ((l == 1) ? 2 : 4);
  endfunction

  // k-th remaining byte (k = 0 is next in address order)
  function automatic logic [BYTE_W-1:0] operand_byte(input logic [DATA_W-1:0] d,
                                                     input cnt_t rem, input int k);
    int idx;
    idx = int'(rem) - 1 - k;
    if (idx < 0 || idx >= LANES) return '0;
    return d[BYTE_W*idx +: BYTE_W];
  endfunction

  function automatic logic [DATA_W-1:0] steer_write(input logic [DATA_W-1:0] d,
                                                    input cnt_t rem, input logic [1:0] a);
    logic [DATA_W-1:0] o;
    o = '0;
    for (int l = 0; l < LANES; l++) begin
      int k;
      k = l - (int'(a) & (lane_span(l) - 1));
      if (k >= 0 && k < int'(rem))
        o[DATA_W-1-BYTE_W*l -: BYTE_W] = operand_byte(d, rem, k);
    end
    return o;
  endfunction

  function automatic logic [DATA_W-1:0] gather_bytes(input logic [DATA_W-1:0] acc,
                                                     input logic [DATA_W-1:0] lanes,
                                                     input logic [1:0] a, input port_w_e w,
                                                     input cnt_t n);
    logic [DATA_W-1:0] r;
    int off;
    r   = acc;
    off = int'(port_offset(a, w));
    for (int i = 0; i < LANES; i++) begin
      int ln;
      ln = off + i;
      if (i < int'(n) && ln < LANES)
        r = {r[DATA_W-BYTE_W-1:0], lanes[DATA_W-1-BYTE_W*ln -: BYTE_W]};
    end
    return r;
  endfunction
endpackage

// File: rtl/dbs_ack_decode.sv
module dbs_ack_decode
  import dbs_pkg::*;
(
  input  logic [1:0] ack_n,
  output logic       ack_seen,
  output port_w_e    port_w
);
  always_comb begin
    port_w   = ack_to_width(ack_n);
    ack_seen = (port_w != PW_NONE);
  end
endmodule

// File: rtl/dbs_ctrl.sv
module dbs_ctrl
  import dbs_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              ack_seen,
  input  port_w_e           port_w,
  output logic              accept,
  output logic              ack_taken,
  output logic              last_cycle,
  output cnt_t              take_n,
  output cnt_t              rem,
  output logic [AW-1:0]     cur_addr,
  output logic [DATA_W-1:0] op_data,
  output logic              wr,
  output logic              in_cycle,
  output logic              busy,
  output logic              done
);
  typedef enum logic [1:0] {ST_IDLE, ST_BUS, ST_GAP} st_e;
  st_e state;

  always_comb begin
    accept     = (state == ST_IDLE) && req_valid;
    ack_taken  = (state == ST_BUS) && ack_seen;
    take_n     = take_count(rem, cur_addr[1:0], port_w);
    last_cycle = ack_taken && (take_n == rem);
    in_cycle   = (state == ST_BUS);
    busy       = (state != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_addr <= '0;
      rem      <= '0;
      op_data  <= '0;
      wr       <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          state    <= ST_BUS;
          cur_addr <= req_addr;
          rem      <= size_decode(req_size);
          op_data  <= req_wdata;
          wr       <= req_write;
        end
        ST_BUS: if (ack_taken) begin
          cur_addr <= cur_addr + AW'(take_n);
          rem      <= rem - take_n;
          if (last_cycle) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            state <= ST_GAP;
          end
        end
        default: state <= ST_BUS;
      endcase
    end
  end
endmodule

// File: rtl/dbs_write_steer.sv
module dbs_write_steer
  import dbs_pkg::*;
(
  input  logic              wr,
  input  logic [DATA_W-1:0] op_data,
  input  cnt_t              rem,
  input  logic [1:0]        addr_lo,
  output logic [DATA_W-1:0] lanes
);
  always_comb lanes = wr ? steer_write(op_data, rem, addr_lo) : '0;
endmodule

// File: rtl/dbs_read_gather.sv
module dbs_read_gather
  import dbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              capture,
  input  logic [DATA_W-1:0] lanes,
  input  logic [1:0]        addr_lo,
  input  port_w_e           port_w,
  input  cnt_t              take_n,
  output logic [DATA_W-1:0] result
);
  always_ff @(posedge clk) begin
    if (!rst_n)       result <= '0;
    else if (clear)   result <= '0;
    else if (capture) result <= gather_bytes(result, lanes, addr_lo, port_w, take_n);
  end
endmodule

// File: rtl/dbs_sequencer.sv
module dbs_sequencer
  import dbs_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              bus_cyc,
  output logic              bus_write,
  output logic [AW-1:0]     bus_addr,
  output logic [1:0]        bus_siz,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic [1:0]        ack_n
);
  // named internal events
  logic              ack_seen;
  port_w_e           port_w;
  logic              accept;
  logic              ack_taken;
  logic              last_cycle;
  cnt_t              take_n;
  cnt_t              rem;
  logic [AW-1:0]     cur_addr;
  logic [DATA_W-1:0] op_data;
  logic              wr;

  dbs_ack_decode u_ack (
    .ack_n    (ack_n),
    .ack_seen (ack_seen),
    .port_w   (port_w)
  );

  dbs_ctrl #(.AW(AW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_size   (req_size),
    .req_wdata  (req_wdata),
    .ack_seen   (ack_seen),
    .port_w     (port_w),
    .accept     (accept),
    .ack_taken  (ack_taken),
    .last_cycle (last_cycle),
    .take_n     (take_n),
    .rem        (rem),
    .cur_addr   (cur_addr),
    .op_data    (op_data),
    .wr         (wr),
    .in_cycle   (bus_cyc),
    .busy       (busy),
    .done       (done)
  );

  dbs_write_steer u_steer (
    .wr      (wr),
    .op_data (op_data),
    .rem     (rem),
    .addr_lo (cur_addr[1:0]),
    .lanes   (bus_wdata)
  );

  dbs_read_gather u_gather (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .capture (ack_taken && !wr),
    .lanes   (bus_rdata),
    .addr_lo (cur_addr[1:0]),
    .port_w  (port_w),
    .take_n  (take_n),
    .result  (rdata)
  );

  always_comb begin
    bus_addr  = cur_addr;
    bus_siz   = size_code(rem);
    bus_write = wr;
  end
endmodule

// File: rtl/dbs_sequencer_chk.sv
module dbs_sequencer_chk
  import dbs_pkg::*;
#(
  parameter int AW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              bus_cyc,
  input logic [AW-1:0]     bus_addr,
  input logic [1:0]        bus_siz,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              ack_taken,
  input logic              last_cycle,
  input cnt_t              take_n
);
  // R6
  hold_while_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc && !ack_taken |=> bus_cyc && $stable(bus_addr) && $stable(bus_siz) && $stable(bus_wdata));

  // R5
  take_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_taken |-> (take_n != 3'd0) && (take_n <= size_decode(bus_siz)));

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_taken && !last_cycle |=> bus_addr == $past(bus_addr) + AW'($past(take_n)));

  // R3
  siz_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_taken && !last_cycle |=> size_decode(bus_siz) == $past(size_decode(bus_siz)) - $past(take_n));

  // R10
  gap_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_taken && !last_cycle |=> !bus_cyc && busy);

  // R10
  gap_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !bus_cyc && !done |=> bus_cyc);

  // R9
  done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_cycle |=> done && !busy);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  cyc_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc |-> busy);
endmodule

bind dbs_sequencer dbs_sequencer_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .bus_cyc    (bus_cyc),
  .bus_addr   (bus_addr),
  .bus_siz    (bus_siz),
  .bus_wdata  (bus_wdata),
  .ack_taken  (ack_taken),
  .last_cycle (last_cycle),
  .take_n     (take_n)
);

// File: tb/dbs_sequencer_test.sv
module dbs_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_write = 0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        busy, done, bus_cyc, bus_write;
  logic [31:0] rdata, bus_addr, bus_wdata;
  logic [1:0]  bus_siz;
  logic [31:0] bus_rdata = '0;
  logic [1:0]  ack_n = 2'b11;

  int n_checks = 0, n_fail = 0;
  logic [7:0]  mem [0:15];
  int          port_seq [0:3];
  int          ncyc;
  logic [1:0]  seen_siz  [0:3];
  logic [31:0] seen_addr [0:3];
  logic [31:0] seen_wd   [0:3];
  bit          poke = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbs_sequencer #(.AW(32)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rdata(rdata), .bus_cyc(bus_cyc), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_siz(bus_siz), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ack_n(ack_n)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] code_of(input int n);
    return (n == 4) ? 2'b00 : n[1:0];
  endfunction

  function automatic logic [1:0] ack_of(input int width);
    return (width == 32) ? 2'b00 : ((width == 16) ? 2'b01 : 2'b10);
  endfunction

  // Slave-side model: runs one transfer, drives acknowledges, stores/returns bytes.
  task automatic do_xfer(input bit wr, input logic [31:0] addr, input int size,
                         input logic [31:0] wdata, input int waits, output logic [31:0] got);
    int rem;
    logic [31:0] a;
    got = '0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = addr; req_size = code_of(size); req_wdata = wdata;
    @(negedge clk);
    req_valid = 0;
    rem = size; a = addr; ncyc = 0;
    while (rem > 0 && ncyc < 4) begin
      int w, off, n;
      if (!bus_cyc) begin
        check(0, "R5", "bus cycle missing", {31'd0, bus_cyc}, 32'd1);
        return;
      end
      seen_siz[ncyc] = bus_siz; seen_addr[ncyc] = bus_addr; seen_wd[ncyc] = bus_wdata;
      check(bus_siz == code_of(rem), "R3", "size code", {30'd0, bus_siz}, {30'd0, code_of(rem)});
      check(bus_addr == a, "R5", "cycle address", bus_addr, a);
      check(bus_write == wr, "R5", "direction", {31'd0, bus_write}, {31'd0, wr});
      if (poke && ncyc == 0) begin
        req_valid = 1; req_write = ~wr; req_addr = 32'h8; req_size = 2'b01;
      end
      for (int i = 0; i < waits; i++) begin
        ack_n = 2'b11;
        @(negedge clk);
        check(bus_cyc && bus_addr == seen_addr[ncyc] && bus_siz == seen_siz[ncyc] &&
              bus_wdata == seen_wd[ncyc], "R6", "hold while no ack (R4 11 waits)",
              bus_wdata, seen_wd[ncyc]);
      end
      w = port_seq[ncyc] / 8;
      off = int'(a) % w;
      n = (rem < w - off) ? rem : w - off;
      if (wr) begin
        for (int i = 0; i < n; i++) mem[(a + i) & 15] = bus_wdata[31 - 8*(off + i) -: 8];
      end else begin
        for (int l = 0; l < 4; l++)
          bus_rdata[31 - 8*l -: 8] = (l < w) ? mem[(a - off + l) & 15] : 8'hEE;
      end
      ack_n = ack_of(port_seq[ncyc]);
      req_valid = 0;
      @(negedge clk);
      ack_n = 2'b11;
      a = a + n; rem = rem - n; ncyc++;
      if (rem > 0) begin
        check(!bus_cyc && busy, "R10", "gap cycle", {31'd0, bus_cyc}, 32'd0);
        @(negedge clk);
      end else begin
        check(done && !busy, "R9", "done with busy low", {30'd0, done, busy}, 32'b10);
        got = rdata;
      end
    end
    @(negedge clk);
    check(!done, "R9", "done lasts one cycle", {31'd0, done}, 32'd0);
  endtask

  function automatic logic [31:0] mem_word(input logic [31:0] addr, input int size);
    logic [31:0] r = '0;
    for (int i = 0; i < size; i++) r = {r[23:0], mem[(addr + i) & 15]};
    return r;
  endfunction

  task automatic check_mem(input logic [31:0] addr, input int size, input logic [31:0] wdata,
                           input string req);
    check(mem_word(addr, size) == (wdata & ((size == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8*size)) - 1))),
          req, "bytes stored by slave", mem_word(addr, size), wdata);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
  endtask

  task automatic t_reset();
    check(!busy && !done && !bus_cyc, "R1", "idle after reset", {29'd0, busy, done, bus_cyc}, 32'd0);
  endtask

  task automatic t_long_odd_16();
    logic [31:0] g;
    clear_mem();
    port_seq = '{16, 16, 16, 16};
    do_xfer(1, 32'h1, 4, 32'h1122_3344, 0, g);
    check(ncyc == 3, "R11", "cycle count", ncyc, 3);
    check(seen_siz[0] == 2'b00 && seen_siz[1] == 2'b11 && seen_siz[2] == 2'b01, "R11", "size codes",
          {26'd0, seen_siz[0], seen_siz[1], seen_siz[2]}, 32'b00_11_01);
    check(seen_addr[0][2:0] == 3'b001 && seen_addr[1][2:0] == 3'b010 && seen_addr[2][2:0] == 3'b100,
          "R11", "offsets", {23'd0, seen_addr[0][2:0], seen_addr[1][2:0], seen_addr[2][2:0]}, 32'o124);
    check_mem(32'h1, 4, 32'h1122_3344, "R7");
  endtask

  task automatic t_word_8bit();
    logic [31:0] g;
    clear_mem();
    port_seq = '{8, 8, 8, 8};
    do_xfer(1, 32'h2, 2, 32'h0000_A5C3, 0, g);
    check(ncyc == 2, "R5", "two byte cycles", ncyc, 2);
    check(seen_wd[0][31:16] == 16'hA5C3, "R7", "first cycle lanes 0 and 1", seen_wd[0], 32'hA5C3_0000);
    check(seen_wd[1][31:24] == 8'hC3, "R7", "second byte on lane 0", seen_wd[1], 32'hC300_0000);
    check_mem(32'h2, 2, 32'hA5C3, "R7");
  endtask

  task automatic t_writes_32();
    logic [31:0] g;
    clear_mem();
    port_seq = '{32, 32, 32, 32};
    do_xfer(1, 32'h4, 4, 32'hDEAD_BEEF, 0, g);
    check(ncyc == 1, "R5", "aligned long in one cycle", ncyc, 1);
    check(seen_wd[0] == 32'hDEAD_BEEF, "R7", "aligned lanes", seen_wd[0], 32'hDEAD_BEEF);
    do_xfer(1, 32'h3, 3, 32'h0077_8899, 0, g);
    check(ncyc == 2, "R5", "three bytes at offset 3", ncyc, 2);
    check(seen_wd[0][7:0] == 8'h77, "R7", "lane 3 carries first byte", seen_wd[0], 32'h0000_0077);
    check_mem(32'h3, 3, 32'h778899, "R7");
  endtask

  task automatic t_mixed_widths();
    logic [31:0] g;
    clear_mem();
    port_seq = '{8, 16, 32, 32};
    do_xfer(1, 32'h2, 4, 32'h0102_0304, 0, g);
    check(ncyc == 3, "R4", "width decoded per acknowledge", ncyc, 3);
    check(seen_addr[2] == 32'h4, "R5", "third cycle address", seen_addr[2], 32'h4);
    check_mem(32'h2, 4, 32'h0102_0304, "R4");
  endtask

  task automatic t_reads();
    logic [31:0] g;
    for (int i = 0; i < 16; i++) mem[i] = 8'h30 + 8'(i);
    port_seq = '{8, 8, 8, 8};
    do_xfer(0, 32'h1, 4, '0, 0, g);
    check(ncyc == 4 && g == mem_word(32'h1, 4), "R8", "long from 8-bit port", g, mem_word(32'h1, 4));
    port_seq = '{32, 32, 32, 32};
    do_xfer(0, 32'h3, 2, '0, 1, g);
    check(ncyc == 2 && g == mem_word(32'h3, 2), "R8", "word across 32-bit boundary", g, mem_word(32'h3, 2));
    port_seq = '{16, 16, 16, 16};
    do_xfer(0, 32'h5, 3, '0, 0, g);
    check(ncyc == 2 && g == mem_word(32'h5, 3), "R8", "three bytes from 16-bit port", g, mem_word(32'h5, 3));
    port_seq = '{32, 32, 32, 32};
    do_xfer(0, 32'hB, 1, '0, 0, g);
    check(g == {24'd0, mem[11]}, "R8", "single byte on lane 3, upper zero", g, {24'd0, mem[11]});
  endtask

  task automatic t_waits();
    logic [31:0] g;
    clear_mem();
    port_seq = '{16, 16, 16, 16};
    do_xfer(1, 32'h6, 4, 32'hCAFE_F00D, 3, g);
    check(ncyc == 2, "R6", "aligned long to 16-bit port with waits", ncyc, 2);
    check_mem(32'h6, 4, 32'hCAFE_F00D, "R6");
  endtask

  task automatic t_busy_request();
    logic [31:0] g;
    clear_mem();
    port_seq = '{8, 8, 8, 8};
    poke = 1;
    do_xfer(1, 32'h0, 2, 32'h0000_5A6B, 2, g);
    poke = 0;
    check(!busy && !bus_cyc, "R2", "request during transfer ignored", {30'd0, busy, bus_cyc}, 32'd0);
    check(mem[8] == 8'h00, "R2", "no access at poked address", {24'd0, mem[8]}, 32'd0);
    check_mem(32'h0, 2, 32'h5A6B, "R2");
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_long_odd_16();
    t_word_8bit();
    t_writes_32();
    t_mixed_widths();
    t_reads();
    t_waits();
    t_busy_request();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule